// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

This block is a memory-mapped watchdog peripheral. It has two 32-bit registers on a plain single-cycle register bus: a control register and a countdown register. Software arms the watchdog by choosing a nonzero expiry action. It refreshes the watchdog by writing a fresh tick count into the countdown register. While the watchdog is armed, the count falls by one on every clock. When it reaches zero, the block raises the chosen request. The choices are a general interrupt, a non-maskable interrupt, or a request for a full chip reset.

The block takes two resets. `por_n` is the power-on reset and clears everything. `sys_rst_n` is the ordinary chip reset that the system issues after a watchdog reset request. It clears all state except one sticky flag. That flag records that the watchdog caused the last reset, so boot software can read it back after the reset.

Top module: `wdog_timer`

## Requirements
- R1: After `por_n` is released, the control register (offset 0x00) and the countdown register (offset 0x04) both read 0, and `irq_gp`, `irq_nmi` and `chip_rst_req` are low.
- R2: A write to offset 0x00 stores only bits [1:0] as the action (0 none, 1 general interrupt, 2 non-maskable interrupt, 3 chip reset). Reading offset 0x00 returns the action in bits [1:0] and the sticky flag in bit 31, with every other bit 0. Bit 31 cannot be written.
- R3: A write to offset 0x04 loads the full 32-bit countdown value. Reads of 0x04 return the current count, and reads of any other offset return 0. Read data is valid in the same cycle as `bus_sel` high with `bus_wr` low, and is 0 otherwise.
- R4: While the action is 0, the count holds its value.
- R5: While the action is nonzero, the count drops by one per clock. It stays at zero once it gets there, until it is reloaded.
- R6: With action 1, the clock edge that takes the count from 1 to 0 sets `irq_gp`. It stays high until a countdown write, or a control write that changes the action.
- R7: With action 2, the same expiry sets `irq_nmi`, with the same hold and clear rules as R6. Rewriting the same action does not clear it.
- R8: With action 3, expiry drives `chip_rst_req` high for exactly one cycle.
- R9: The sticky flag (control bit 31) is set on the same edge that raises `chip_rst_req`. It survives `sys_rst_n` and is cleared only by `por_n`.
- R10: If a countdown write lands in the cycle where the count would step from 1 to 0, the written value is loaded and no expiry happens.
- R11: `sys_rst_n` clears the action, the count and all request outputs.
- R12: A count of 0xFFFFFFFF is accepted and counts down like any other value.
- R13: A control write takes effect on the same clock edge it is written. Writing a nonzero action starts the countdown on that edge, and writing 0 stops it on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| sys_rst_n | input | 1 | Chip reset, active low, keeps the sticky flag |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational |
| irq_gp | output | 1 | General interrupt request, level |
| irq_nmi | output | 1 | Non-maskable interrupt request, level |
| chip_rst_req | output | 1 | Chip reset request, one-cycle pulse |

## Verification
The bench uses the default parameters: a 32-bit counter, a 32-bit data path and a 4-bit address, which includes two unmapped offsets. Because the counter is full width, an all-ones load can be checked directly. Short loads of a few ticks bring every expiry path within a few dozen cycles. A bench-driven chip reset after the reset request shows that the sticky flag survives `sys_rst_n` and clears only on `por_n`.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_IRQ   = 2'd1,
        ACT_NMI   = 2'd2,
        ACT_CHRST = 2'd3
    } wdog_act_e;

    localparam int CTRL_OFS  = 0;
    localparam int COUNT_OFS = 4;
endpackage

// File: rtl/wdog_regif.sv
module wdog_regif
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  wdog_act_e         act_q,
    input  logic              flag_q,
    input  logic [CNT_W-1:0]  count_q,
    output logic              ctrl_we,
    output logic              count_we,
    output wdog_act_e         wr_act,
    output logic [CNT_W-1:0]  load_val,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] COUNT_A = ADDR_W'(COUNT_OFS);

    logic              hit_ctrl;
    logic              hit_count;
    logic [DATA_W-1:0] ctrl_view;
    logic [DATA_W-1:0] count_view;

    assign hit_ctrl  = bus_sel && (bus_addr == CTRL_A);
    assign hit_count = bus_sel && (bus_addr == COUNT_A);
    assign ctrl_we   = hit_ctrl && bus_wr;
    assign count_we  = hit_count && bus_wr;
    assign wr_act    = wdog_act_e'(bus_wdata[1:0]);
    assign load_val  = bus_wdata[CNT_W-1:0];

    always_comb begin
        ctrl_view           = '0;
        ctrl_view[1:0]      = act_q;
        ctrl_view[DATA_W-1] = flag_q;
    end

    generate
        if (CNT_W < DATA_W) begin : g_pad
            assign count_view = {{(DATA_W-CNT_W){1'b0}}, count_q};
        end else begin : g_full
            assign count_view = count_q;
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (!bus_wr) begin
            if (hit_ctrl)
                bus_rdata = ctrl_view;
            else if (hit_count)
                bus_rdata = count_view;
        end
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic [CNT_W-1:0] count_q,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        expire = 1'b0;
        if (load_en) begin
            s_d.cnt = load_val;
        end else if (run && (s_q.cnt != '0)) begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
            expire  = (s_q.cnt == CNT_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign count_q = s_q.cnt;
endmodule

// File: rtl/wdog_action.sv
module wdog_action
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctrl_we,
    input  wdog_act_e wr_act,
    input  logic      count_we,
    input  logic      expire,
    output wdog_act_e act_nxt,
    output wdog_act_e act_q,
    output logic      irq_gp,
    output logic      irq_nmi,
    output logic      rst_req
);
    typedef struct packed {
        wdog_act_e act;
        logic      gp;
        logic      nmi;
        logic      req;
    } act_state_t;

    act_state_t s_d, s_q;
    logic       clr_lvl;

    assign act_nxt = ctrl_we ? wr_act : s_q.act;
    assign clr_lvl = count_we || (ctrl_we && (wr_act != s_q.act));

    always_comb begin
        s_d     = s_q;
        s_d.act = act_nxt;
        s_d.req = 1'b0;
        if (clr_lvl) begin
            s_d.gp  = 1'b0;
            s_d.nmi = 1'b0;
        end
        if (expire) begin
            case (act_nxt)
                ACT_IRQ:   s_d.gp  = 1'b1;
                ACT_NMI:   s_d.nmi = 1'b1;
                ACT_CHRST: s_d.req = 1'b1;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '{act: ACT_NONE, gp: 1'b0, nmi: 1'b0, req: 1'b0};
        else
            s_q <= s_d;
    end

    assign act_q   = s_q.act;
    assign irq_gp  = s_q.gp;
    assign irq_nmi = s_q.nmi;
    assign rst_req = s_q.req;
endmodule

// File: rtl/wdog_sticky.sv
module wdog_sticky (
    input  logic clk,
    input  logic por_n,
    input  logic set,
    output logic flag_q
);
    logic flag_d;

    always_comb begin
        flag_d = flag_q | set;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            flag_q <= 1'b0;
        else
            flag_q <= flag_d;
    end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_gp,
    output logic              irq_nmi,
    output logic              chip_rst_req
);
    logic             core_rst_n;
    logic             ctrl_we;
    logic             count_we;
    wdog_act_e        wr_act;
    wdog_act_e        act_nxt;
    wdog_act_e        act_q;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] count_q;
    logic             expire;
    logic             wd_flag;
    logic             req_set;

    assign core_rst_n = por_n & sys_rst_n;
    assign req_set    = expire && (act_nxt == ACT_CHRST);

    wdog_regif #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_regif (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .act_q    (act_q),
        .flag_q   (wd_flag),
        .count_q  (count_q),
        .ctrl_we  (ctrl_we),
        .count_we (count_we),
        .wr_act   (wr_act),
        .load_val (load_val),
        .bus_rdata(bus_rdata)
    );

    wdog_counter #(
        .CNT_W(CNT_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (core_rst_n),
        .load_en (count_we),
        .load_val(load_val),
        .run     (act_nxt != ACT_NONE),
        .count_q (count_q),
        .expire  (expire)
    );

    wdog_action u_action (
        .clk     (clk),
        .rst_n   (core_rst_n),
        .ctrl_we (ctrl_we),
        .wr_act  (wr_act),
        .count_we(count_we),
        .expire  (expire),
        .act_nxt (act_nxt),
        .act_q   (act_q),
        .irq_gp  (irq_gp),
        .irq_nmi (irq_nmi),
        .rst_req (chip_rst_req)
    );

    wdog_sticky u_sticky (
        .clk   (clk),
        .por_n (por_n),
        .set   (req_set),
        .flag_q(wd_flag)
    );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             por_n,
    input logic             sys_rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic             irq_gp,
    input logic             irq_nmi,
    input logic             chip_rst_req,
    input logic [1:0]       act_q,
    input logic [CNT_W-1:0] count_q,
    input logic             wd_flag
);
    logic any_wr;
    assign any_wr = bus_sel && bus_wr;

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!(por_n && sys_rst_n))
        chip_rst_req |=> !chip_rst_req); // R8

    AST_FLAG_WITH_REQ: assert property (@(posedge clk) disable iff (!por_n)
        chip_rst_req |-> wd_flag); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        wd_flag |=> wd_flag); // R9

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!(por_n && sys_rst_n))
        $onehot0({irq_gp, irq_nmi, chip_rst_req})); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!(por_n && sys_rst_n))
        (act_q == 2'd0 && !any_wr) |=> $stable(count_q)); // R4

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!(por_n && sys_rst_n))
        (count_q == '0 && !any_wr) |=> (count_q == '0)); // R5

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!(por_n && sys_rst_n))
        (act_q != 2'd0 && count_q != '0 && !any_wr) |=> (count_q == $past(count_q) - CNT_W'(1))); // R5

    AST_GP_HOLD: assert property (@(posedge clk) disable iff (!(por_n && sys_rst_n))
        (irq_gp && !any_wr) |=> irq_gp); // R6

    AST_NMI_HOLD: assert property (@(posedge clk) disable iff (!(por_n && sys_rst_n))
        (irq_nmi && !any_wr) |=> irq_nmi); // R7
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .sys_rst_n   (sys_rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .irq_gp      (irq_gp),
    .irq_nmi     (irq_nmi),
    .chip_rst_req(chip_rst_req),
    .act_q       (act_q),
    .count_q     (count_q),
    .wd_flag     (wd_flag)
);

// File: tb/sim_wdog_timer.sv
`timescale 1ns/1ps
module sim_wdog_timer;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_gp, irq_nmi, chip_rst_req;

    int n_tests = 0;
    int n_fail  = 0;
    int req_seen = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_cnt = '0;
    logic [1:0]  m_act = '0;
    logic        m_flag = 1'b0, m_gp = 1'b0, m_nmi = 1'b0, m_req = 1'b0;

    always #2.5 clk = ~clk;

    wdog_timer u0 (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_gp(irq_gp), .irq_nmi(irq_nmi), .chip_rst_req(chip_rst_req)
    );

    always @(posedge clk) begin
        if (!por_n) begin
            m_cnt = '0; m_act = '0; m_flag = 0; m_gp = 0; m_nmi = 0; m_req = 0;
        end else if (!sys_rst_n) begin
            m_cnt = '0; m_act = '0; m_gp = 0; m_nmi = 0; m_req = 0;
        end else begin
            bit twe, cwe, fire;
            logic [1:0] nact;
            twe  = bus_sel && bus_wr && bus_addr == 4'h4;
            cwe  = bus_sel && bus_wr && bus_addr == 4'h0;
            nact = cwe ? bus_wdata[1:0] : m_act;
            fire = 0;
            m_req = 0;
            if (twe || (cwe && nact != m_act)) begin
                m_gp = 0; m_nmi = 0;
            end
            if (twe) m_cnt = bus_wdata;
            else if (nact != 0 && m_cnt != 0) begin
                fire  = (m_cnt == 1);
                m_cnt = m_cnt - 1;
            end
            m_act = nact;
            if (fire) begin
                if (nact == 2'd1) m_gp = 1;
                else if (nact == 2'd2) m_nmi = 1;
                else if (nact == 2'd3) begin m_req = 1; m_flag = 1; end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (chip_rst_req === 1'b1) req_seen++;
        if (por_n && sys_rst_n) begin
            logic [31:0] erd;
            erd = '0;
            if (bus_sel && !bus_wr) begin
                if (bus_addr == 4'h0) erd = {m_flag, 29'b0, m_act};
                else if (bus_addr == 4'h4) erd = m_cnt;
            end
            chk("R3 rdata", bus_rdata, erd);
            chk("R6 irq_gp", {31'b0, irq_gp}, {31'b0, m_gp});
            chk("R7 irq_nmi", {31'b0, irq_nmi}, {31'b0, m_nmi});
            chk("R8 chip_rst_req", {31'b0, chip_rst_req}, {31'b0, m_req});
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            bus_sel = 0; bus_wr = 0; bus_wdata = '0;
        end
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        chk(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 por_n = 1;
        // R1 reset state
        rd_chk("R1 ctrl", 4'h0, 32'h0);
        rd_chk("R1 count", 4'h4, 32'h0);
        chk("R1 outputs", {29'b0, irq_gp, irq_nmi, chip_rst_req}, 32'h0);
        rd_chk("R3 unmapped", 4'h8, 32'h0);
        // R4 hold when disarmed
        wr(4'h4, 32'd10);
        idle(5);
        rd_chk("R4 hold", 4'h4, 32'd10);
        // R2 only action bits stored
        wr(4'h0, 32'h7FFF_FFFC);
        rd_chk("R2 ctrl write 0", 4'h0, 32'h0);
        wr(4'h0, 32'hFFFF_FFFD);
        rd_chk("R2 R13 ctrl action 1", 4'h0, 32'h1);
        idle(15);
        chk("R6 gp set", {31'b0, irq_gp}, 32'h1);
        rd_chk("R5 stays zero", 4'h4, 32'h0);
        idle(5);
        chk("R6 gp held", {31'b0, irq_gp}, 32'h1);
        wr(4'h4, 32'd3);
        idle(1);
        @(negedge clk);
        chk("R6 gp cleared by reload", {31'b0, irq_gp}, 32'h0);
        idle(6);
        chk("R6 gp set again", {31'b0, irq_gp}, 32'h1);
        wr(4'h0, 32'h2);
        idle(1);
        @(negedge clk);
        chk("R6 gp cleared by action change", {31'b0, irq_gp}, 32'h0);
        // R7 nmi
        wr(4'h4, 32'd4);
        idle(8);
        chk("R7 nmi set", {31'b0, irq_nmi}, 32'h1);
        wr(4'h0, 32'h2);
        idle(1);
        @(negedge clk);
        chk("R7 nmi kept on same action", {31'b0, irq_nmi}, 32'h1);
        wr(4'h0, 32'h0);
        idle(1);
        @(negedge clk);
        chk("R7 nmi cleared", {31'b0, irq_nmi}, 32'h0);
        // R10 write wins over final decrement
        wr(4'h0, 32'h1);
        wr(4'h4, 32'd2);
        idle(1);
        wr(4'h4, 32'd5);
        idle(1);
        @(negedge clk);
        chk("R10 no expiry", {31'b0, irq_gp}, 32'h0);
        rd_chk("R10 reload value", 4'h4, 32'd4);
        wr(4'h0, 32'h0);
        idle(2);
        // R12 full-range load
        wr(4'h4, 32'hFFFF_FFFF);
        wr(4'h0, 32'h3);
        idle(3);
        rd_chk("R12 R13 full range", 4'h4, 32'hFFFF_FFFB);
        wr(4'h0, 32'h0);
        idle(2);
        // R8 R9 reset request
        req_seen = 0;
        wr(4'h4, 32'd3);
        wr(4'h0, 32'h3);
        idle(8);
        chk("R8 single pulse", req_seen, 32'd1);
        rd_chk("R9 flag set", 4'h0, 32'h8000_0003);
        @(posedge clk); #1 sys_rst_n = 0; bus_sel = 0;
        repeat (2) @(posedge clk);
        #1 sys_rst_n = 1;
        rd_chk("R9 R11 flag survives", 4'h0, 32'h8000_0000);
        rd_chk("R11 count cleared", 4'h4, 32'h0);
        chk("R11 outputs", {29'b0, irq_gp, irq_nmi, chip_rst_req}, 32'h0);
        @(posedge clk); #1 por_n = 0; bus_sel = 0;
        repeat (2) @(posedge clk);
        #1 por_n = 1;
        rd_chk("R9 flag cleared by por", 4'h0, 32'h0);
        idle(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule